// File: doc/BRIEF.md
# Zero-Skipping Stride-2 Upsampling Transpose Convolution

This block is the upsampling stage of an image decoder. It takes a compressed feature map of 16x16 positions with eight channels of 6-bit unsigned data and rebuilds a 32x32 picture with three 8-bit colour channels. The stride is 2 and the kernel window is 2x2, so the windows do not overlap. Each input position therefore owns exactly one 2x2 patch of output pixels. Each output value is the sum, over the eight input channels, of one input sample times one signed kernel tap. No zero-padded upsampled map is ever built, and no multiply is ever spent on an inserted zero.

The 96 signed 8-bit kernel taps are loaded beforehand through a plain write port. Input arrives one position per beat, carrying all eight channels, in raster order. The block buffers one input row. It then emits the two output rows that row produces, one colour sample per beat with the three colours of a pixel back to back. A last flag marks the final sample of the frame. Each channel sum is 18 bits signed. A programmable right shift with round-half-up, followed by clamping to the range 0..255, reduces it to the output byte.

Top module: `zs_upconv`

## Requirements
- R1: After reset `out_valid` and `out_last` are 0 and `in_ready` is 1.
- R2: A write with `wt_we` high stores `wt_data` as tap w[c][ky][kx][co] at address ((ky*2+kx)*3+co)*8+c, where c is the input channel, ky/kx are the row/column parity inside the 2x2 patch, and co is the colour. Addresses 96 and above are ignored.
- R3: Output sample (co, y, x) is built from the sum S over c of in[c][y/2][x/2] * w[c][y%2][x%2][co]. Input samples are unsigned and taps are signed.
- R4: The emitted byte is clamp((S + B) >>> `cfg_shift`, 0, 255), where B = 2^(`cfg_shift`-1) when `cfg_shift` > 0 and B = 0 otherwise.
- R5: Output samples leave in order: y from 0 to 31, then x from 0 to 31 within a row, then co from 0 to 2 (red, green, blue) within a pixel.
- R6: Each input beat is one position, with channel c in bits [6c+5:6c]. Beats arrive in raster order over the 16x16 map. After the 16th beat of a row is accepted, `in_ready` is low on the next cycle, and it stays low until both output rows for that row have been handed to the output register.
- R7: `out_last` is 1 on the 3072nd sample of a frame and 0 on every other sample.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` keep their values. No sample is dropped or repeated.
- R9: Frames follow one another without a reset. The sample after a last flag is sample (0,0,0) of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_shift | input | 4 | Right-shift amount used in the requantisation step |
| wt_we | input | 1 | Tap write strobe |
| wt_addr | input | 7 | Tap address |
| wt_data | input | 8 | Signed tap value |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with in_valid |
| in_data | input | 48 | Eight 6-bit channel samples of one position |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the sample |
| out_data | output | 8 | Unsigned output sample |
| out_last | output | 1 | Marks the final sample of a frame |

## Verification
The hardest situation to reach is a long downstream stall. It is hardest when the stall lands on the final sample of a row, while the controller is about to hand the input side back to row filling, and when it lands on the frame's last sample just before the next frame starts. The bench reaches these cases by running whole frames under several `out_ready` patterns: alternating, pseudo-random, and open only one cycle in seven. Every held cycle is compared with the one before it. The addressing of individual taps is isolated by a frame in which only one tap is nonzero. Clamping and rounding are driven by full-scale inputs with extreme taps and by a large shift.

// File: rtl/upconv_pkg.sv
package upconv_pkg;
   // Controller phase: collecting one input row, or emitting its two output rows.
   typedef enum logic {
      PH_FILL = 1'b0,
      PH_EMIT = 1'b1
   } phase_t;
endpackage

// File: rtl/upconv_wbank.sv
module upconv_wbank #(
   parameter int N_CI    = 8,
   parameter int N_CO    = 3,
   parameter int W_W     = 8,
   parameter int WADDR_W = 7,
   parameter int CO_W    = 2
) (
   input  logic                  clk,
   input  logic                  wr_en,
   input  logic [WADDR_W-1:0]    wr_addr,
   input  logic [W_W-1:0]        wr_data,
   input  logic                  sel_ky,
   input  logic                  sel_kx,
   input  logic [CO_W-1:0]       sel_co,
   output logic [N_CI*W_W-1:0]   taps_o
);
   localparam int DEPTH = 4 * N_CI * N_CO;

   if (DEPTH > (1 << WADDR_W)) begin : g_bad_addr
      $error("upconv_wbank: WADDR_W too narrow for %0d taps", DEPTH);
   end

   logic [W_W-1:0] mem [DEPTH];
   int             base;

   always_ff @(posedge clk) begin
      if (wr_en && (int'(wr_addr) < DEPTH)) begin
         mem[int'(wr_addr)] <= wr_data;
      end
   end

   // Taps for one (ky, kx, colour) sit in consecutive channel slots.
   always_comb begin
      base = ((int'(sel_ky) * 2 + int'(sel_kx)) * N_CO + int'(sel_co)) * N_CI;
   end

   for (genvar c = 0; c < N_CI; c++) begin : g_tap
      assign taps_o[c*W_W +: W_W] = mem[base + c];
   end
endmodule

// File: rtl/upconv_rowbuf.sv
module upconv_rowbuf #(
   parameter int DEPTH = 16,
   parameter int IDX_W = 4,
   parameter int DW    = 48
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [DW-1:0]    wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [DW-1:0]    rd_data
);
   if (DEPTH > (1 << IDX_W)) begin : g_bad_idx
      $error("upconv_rowbuf: IDX_W too narrow for depth %0d", DEPTH);
   end

   logic [DW-1:0] row [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         row[wr_idx] <= wr_data;
      end
   end

   assign rd_data = row[rd_idx];
endmodule

// File: rtl/upconv_dot.sv
module upconv_dot #(
   parameter int N_CI     = 8,
   parameter int PIX_W    = 6,
   parameter int W_W      = 8,
   parameter int ACC_W    = 18,
   parameter int OUT_W    = 8,
   parameter int SH_W     = 4,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic [N_CI*PIX_W-1:0] pix_i,
   input  logic [N_CI*W_W-1:0]   taps_i,
   input  logic [SH_W-1:0]       shift_i,
   output logic [OUT_W-1:0]      pix_o
);
   localparam int NEED_W = PIX_W + W_W + 1 + $clog2(N_CI);
   localparam logic signed [ACC_W:0] MAXV = (ACC_W+1)'((1 << OUT_W) - 1);

   if (ACC_W < NEED_W) begin : g_bad_acc
      $error("upconv_dot: ACC_W %0d below the %0d bits the sum needs", ACC_W, NEED_W);
   end
   if (OUT_W >= ACC_W) begin : g_bad_out
      $error("upconv_dot: OUT_W must be narrower than ACC_W");
   end

   logic signed [ACC_W-1:0] prod [N_CI];
   logic signed [ACC_W-1:0] acc;
   logic signed [ACC_W:0]   bias;
   logic signed [ACC_W:0]   wide;
   logic signed [ACC_W:0]   shr;

   // One product per input channel: unsigned sample times signed tap.
   for (genvar c = 0; c < N_CI; c++) begin : g_mul
      logic signed [ACC_W-1:0] px_e;
      logic signed [ACC_W-1:0] tp_e;
      assign px_e = ACC_W'({1'b0, pix_i[c*PIX_W +: PIX_W]});
      assign tp_e = {{(ACC_W-W_W){taps_i[c*W_W+W_W-1]}}, taps_i[c*W_W +: W_W]};
      assign prod[c] = px_e * tp_e;
   end

   always_comb begin
      acc = '0;
      for (int c = 0; c < N_CI; c++) begin
         acc = acc + prod[c];
      end
   end

   // Requantisation variant: round-half-up or plain truncation.
   if (ROUND_EN) begin : g_round
      always_comb begin
         if (shift_i == '0) bias = '0;
         else               bias = (ACC_W+1)'(1) <<< (shift_i - SH_W'(1));
      end
   end else begin : g_trunc
      assign bias = '0;
   end

   always_comb begin
      wide = {acc[ACC_W-1], acc} + bias;
      shr  = wide >>> shift_i;
      if (shr < 0)         pix_o = '0;
      else if (shr > MAXV) pix_o = '1;
      else                 pix_o = shr[OUT_W-1:0];
   end

   // R3: a sum of zero must leave as zero for any shift.
   always_comb begin
      if (acc == '0) begin
         assert_zero_sum_R3: assert (pix_o == '0);
      end
   end
endmodule

// File: rtl/upconv_seq.sv
module upconv_seq
   import upconv_pkg::*;
#(
   parameter int IN_DIM = 16,
   parameter int N_CO   = 3,
   parameter int COL_W  = 4,
   parameter int OCOL_W = 5,
   parameter int CO_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              out_valid,
   input  logic              out_ready,
   output logic              in_ready,
   output logic              fill_we,
   output logic [COL_W-1:0]  fill_col,
   output logic              step,
   output logic [COL_W-1:0]  rd_col,
   output logic              ky,
   output logic              kx,
   output logic [CO_W-1:0]   co,
   output logic              final_o
);
   localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(IN_DIM - 1);
   localparam logic [OCOL_W-1:0] OCOL_LAST = OCOL_W'(2 * IN_DIM - 1);
   localparam logic [CO_W-1:0]   CO_LAST   = CO_W'(N_CO - 1);

   if (OCOL_W != COL_W + 1) begin : g_bad_ocol
      $error("upconv_seq: OCOL_W must be COL_W + 1");
   end

   phase_t              phase;
   logic [COL_W-1:0]    in_row;
   logic                par;
   logic [OCOL_W-1:0]   ocol;

   assign in_ready = (phase == PH_FILL);
   assign fill_we  = in_ready && in_valid;
   assign step     = (phase == PH_EMIT) && (!out_valid || out_ready);
   assign rd_col   = ocol[OCOL_W-1:1];
   assign ky       = par;
   assign kx       = ocol[0];
   assign final_o  = (in_row == COL_LAST) && par && (ocol == OCOL_LAST) && (co == CO_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_FILL;
         fill_col <= '0;
         in_row   <= '0;
         par      <= 1'b0;
         ocol     <= '0;
         co       <= '0;
      end else if (phase == PH_FILL) begin
         if (in_valid) begin
            if (fill_col == COL_LAST) begin
               fill_col <= '0;
               phase    <= PH_EMIT;
               par      <= 1'b0;
               ocol     <= '0;
               co       <= '0;
            end else begin
               fill_col <= fill_col + COL_W'(1);
            end
         end
      end else if (step) begin
         if (co != CO_LAST) begin
            co <= co + CO_W'(1);
         end else begin
            co <= '0;
            if (ocol != OCOL_LAST) begin
               ocol <= ocol + OCOL_W'(1);
            end else begin
               ocol <= '0;
               if (!par) begin
                  par <= 1'b1;
               end else begin
                  par    <= 1'b0;
                  phase  <= PH_FILL;
                  in_row <= (in_row == COL_LAST) ? '0 : in_row + COL_W'(1);
               end
            end
         end
      end
   end

   // R6: the cycle after a row's last beat is taken, input is closed.
   assert_row_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && (fill_col == COL_LAST)) |=> !in_ready);
endmodule

// File: rtl/zs_upconv.sv
module zs_upconv #(
   parameter int N_CI     = 8,
   parameter int N_CO     = 3,
   parameter int IN_DIM   = 16,
   parameter int PIX_W    = 6,
   parameter int W_W      = 8,
   parameter int ACC_W    = 18,
   parameter int OUT_W    = 8,
   parameter int SH_W     = 4,
   parameter bit ROUND_EN = 1'b1,
   localparam int OUT_DIM = 2 * IN_DIM,
   localparam int N_TAP   = 4 * N_CI * N_CO,
   localparam int WADDR_W = $clog2(N_TAP),
   localparam int BEAT_W  = N_CI * PIX_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SH_W-1:0]    cfg_shift,
   input  logic               wt_we,
   input  logic [WADDR_W-1:0] wt_addr,
   input  logic [W_W-1:0]     wt_data,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [BEAT_W-1:0]  in_data,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [OUT_W-1:0]   out_data,
   output logic               out_last
);
   localparam int COL_W  = (IN_DIM > 1) ? $clog2(IN_DIM) : 1;
   localparam int OCOL_W = COL_W + 1;
   localparam int CO_W   = (N_CO > 1) ? $clog2(N_CO) : 1;
   localparam int TOT    = OUT_DIM * OUT_DIM * N_CO;
   localparam int TOT_W  = $clog2(TOT + 1);

   if (N_CI < 1 || N_CO < 1 || IN_DIM < 2) begin : g_bad_dims
      $error("zs_upconv: channel counts must be positive and IN_DIM at least 2");
   end
   if (SH_W > 5) begin : g_bad_shift
      $error("zs_upconv: SH_W above 5 exceeds any useful shift");
   end

   logic                 fill_we;
   logic [COL_W-1:0]     fill_col;
   logic                 step;
   logic [COL_W-1:0]     rd_col;
   logic                 ky;
   logic                 kx;
   logic [CO_W-1:0]      co;
   logic                 fin;
   logic [N_CI*W_W-1:0]  taps;
   logic [BEAT_W-1:0]    row_px;
   logic [OUT_W-1:0]     px_next;

   upconv_seq #(
      .IN_DIM (IN_DIM), .N_CO (N_CO), .COL_W (COL_W), .OCOL_W (OCOL_W), .CO_W (CO_W)
   ) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .in_ready  (in_ready),
      .fill_we   (fill_we),
      .fill_col  (fill_col),
      .step      (step),
      .rd_col    (rd_col),
      .ky        (ky),
      .kx        (kx),
      .co        (co),
      .final_o   (fin)
   );

   upconv_wbank #(
      .N_CI (N_CI), .N_CO (N_CO), .W_W (W_W), .WADDR_W (WADDR_W), .CO_W (CO_W)
   ) i_wbank (
      .clk     (clk),
      .wr_en   (wt_we),
      .wr_addr (wt_addr),
      .wr_data (wt_data),
      .sel_ky  (ky),
      .sel_kx  (kx),
      .sel_co  (co),
      .taps_o  (taps)
   );

   upconv_rowbuf #(
      .DEPTH (IN_DIM), .IDX_W (COL_W), .DW (BEAT_W)
   ) i_rowbuf (
      .clk     (clk),
      .wr_en   (fill_we),
      .wr_idx  (fill_col),
      .wr_data (in_data),
      .rd_idx  (rd_col),
      .rd_data (row_px)
   );

   upconv_dot #(
      .N_CI (N_CI), .PIX_W (PIX_W), .W_W (W_W), .ACC_W (ACC_W),
      .OUT_W (OUT_W), .SH_W (SH_W), .ROUND_EN (ROUND_EN)
   ) i_dot (
      .pix_i   (row_px),
      .taps_i  (taps),
      .shift_i (cfg_shift),
      .pix_o   (px_next)
   );

   // Output holding register: loaded only when empty or being drained.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_last  <= 1'b0;
      end else if (step) begin
         out_valid <= 1'b1;
         out_data  <= px_next;
         out_last  <= fin;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   // Per-frame count of delivered samples, used by the last-flag checks.
   logic [TOT_W-1:0] sent;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sent <= '0;
      end else if (out_valid && out_ready) begin
         sent <= out_last ? '0 : sent + TOT_W'(1);
      end
   end

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

   assert_last_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |-> (sent == TOT_W'(TOT - 1)));

   assert_last_seen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && (sent == TOT_W'(TOT - 1))) |-> out_last);
endmodule

// File: tb/test_zs_upconv.sv
module test_zs_upconv;
   localparam int NCI = 8;
   localparam int NCO = 3;
   localparam int DIM = 16;
   localparam int ODIM = 32;
   localparam int TOT = ODIM * ODIM * NCO;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  cfg_shift = '0;
   logic        wt_we = 1'b0;
   logic [6:0]  wt_addr = '0;
   logic [7:0]  wt_data = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [47:0] in_data = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [7:0]  out_data;
   logic        out_last;

   always #5 clk = ~clk;

   zs_upconv i_zs_upconv (
      .clk (clk), .rst_n (rst_n), .cfg_shift (cfg_shift),
      .wt_we (wt_we), .wt_addr (wt_addr), .wt_data (wt_data),
      .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
      .out_valid (out_valid), .out_ready (out_ready),
      .out_data (out_data), .out_last (out_last)
   );

   int img [DIM][DIM][NCI];
   int wt  [NCI][2][2][NCO];
   int n_vec = 0;
   int n_err = 0;
   int lcg = 12345;

   function automatic int rnd();
      lcg = lcg * 1103515245 + 12345;
      return (lcg >>> 16) & 32'h7fff;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int model(int y, int x, int co, int sh);
      int s = 0;
      int b;
      int r;
      for (int c = 0; c < NCI; c++) s += img[y/2][x/2][c] * wt[c][y%2][x%2][co];
      b = (sh > 0) ? (1 << (sh - 1)) : 0;
      r = (s + b) >>> sh;
      if (r < 0) r = 0;
      if (r > 255) r = 255;
      return r;
   endfunction

   task automatic load_taps();
      for (int c = 0; c < NCI; c++)
         for (int ky = 0; ky < 2; ky++)
            for (int kx = 0; kx < 2; kx++)
               for (int co = 0; co < NCO; co++) begin
                  @(negedge clk);
                  wt_we   = 1'b1;
                  wt_addr = 7'(((ky * 2 + kx) * NCO + co) * NCI + c);
                  wt_data = 8'(wt[c][ky][kx][co]);
               end
      @(negedge clk);
      wt_we = 1'b0;
   endtask

   function automatic bit ready_at(int mode, int cyc);
      case (mode)
         0: return 1'b1;
         1: return cyc[0];
         2: return (rnd() % 10) < 6;
         default: return (cyc % 7) == 0;
      endcase
   endfunction

   task automatic run_frame(input int mode, input int sh, input string req);
      cfg_shift = 4'(sh);
      @(negedge clk);
      fork
         begin : drive
            for (int y = 0; y < DIM; y++)
               for (int x = 0; x < DIM; x++) begin
                  in_valid = 1'b1;
                  for (int c = 0; c < NCI; c++) in_data[c*6 +: 6] = 6'(img[y][x][c]);
                  while (1) begin
                     bit took = in_ready;
                     @(negedge clk);
                     if (took) break;
                  end
                  if (x == DIM - 1) begin
                     in_valid = 1'b0;
                     if (y == 0)
                        chk(!in_ready, "R6", "in_ready after row", int'(in_ready), 0);
                  end
               end
            in_valid = 1'b0;
         end
         begin : collect
            int idx = 0;
            int cyc = 0;
            bit held = 1'b0;
            logic [7:0] hd = '0;
            logic hl = 1'b0;
            while (idx < TOT) begin
               out_ready = ready_at(mode, cyc);
               if (held)
                  chk(out_valid && out_data == hd && out_last == hl, "R8", "stalled sample",
                      int'(out_data), int'(hd));
               held = 1'b0;
               if (out_valid && out_ready) begin
                  int y = idx / (ODIM * NCO);
                  int x = (idx / NCO) % ODIM;
                  int co = idx % NCO;
                  int e = model(y, x, co, sh);
                  chk(int'(out_data) == e, req, $sformatf("R5 sample y%0d x%0d c%0d", y, x, co),
                      int'(out_data), e);
                  chk(out_last == (idx == TOT - 1), "R7", $sformatf("last at %0d", idx),
                      int'(out_last), int'(idx == TOT - 1));
                  idx++;
               end else if (out_valid) begin
                  held = 1'b1;
                  hd = out_data;
                  hl = out_last;
               end
               cyc++;
               @(negedge clk);
            end
            out_ready = 1'b0;
         end
      join
   endtask

   task automatic set_img(input int p);
      for (int y = 0; y < DIM; y++)
         for (int x = 0; x < DIM; x++)
            for (int c = 0; c < NCI; c++)
               img[y][x][c] = (p == 3) ? 63 : (y * 7 + x * 3 + c * 11 + p * 13) % 64;
   endtask

   task automatic set_wt(input int m);
      for (int c = 0; c < NCI; c++)
         for (int ky = 0; ky < 2; ky++)
            for (int kx = 0; kx < 2; kx++)
               for (int co = 0; co < NCO; co++)
                  case (m)
                     0: wt[c][ky][kx][co] = (c == 5 && ky == 1 && kx == 0 && co == 2) ? 3 : 0;
                     1: wt[c][ky][kx][co] = (c + ky * 2 + kx + co) % 4;
                     2: wt[c][ky][kx][co] = ((c * 37 + ky * 19 + kx * 7 + co * 53) % 255) - 127;
                     default: wt[c][ky][kx][co] = (((c + ky + kx + co) % 2) == 0) ? 127 : -128;
                  endcase
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
      chk(out_last == 1'b0, "R1", "out_last in reset", int'(out_last), 0);
      chk(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
   endtask

   task automatic t_tap_address();
      set_wt(0);
      load_taps();
      @(negedge clk);
      wt_we = 1'b1; wt_addr = 7'd100; wt_data = 8'd77;
      @(negedge clk);
      wt_we = 1'b0;
      set_img(0);
      run_frame(0, 0, "R2");
   endtask

   task automatic t_basic();
      set_wt(1);
      load_taps();
      set_img(1);
      run_frame(0, 2, "R3");
   endtask

   task automatic t_round();
      set_wt(2);
      load_taps();
      set_img(2);
      run_frame(1, 5, "R4");
   endtask

   task automatic t_saturate();
      set_wt(3);
      load_taps();
      set_img(3);
      run_frame(2, 0, "R4");
   endtask

   task automatic t_back_to_back();
      set_wt(2);
      load_taps();
      set_img(4);
      run_frame(3, 3, "R9");
      set_img(5);
      run_frame(2, 1, "R9");
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
   end

   initial begin
      t_reset();
      t_tap_address();
      t_basic();
      t_round();
      t_saturate();
      t_back_to_back();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
   end
endmodule